// File: doc/BRIEF.md
# Ripple Pulse Counter with Twisted-Ring Decode

This block counts pulses on a single input, modulo 8. The counter is a chain of three toggle stages. Each stage is a D flip-flop whose inverted output feeds its own D input. Only the first stage sees the pulse input. Every later stage is clocked by the output of the stage before it, so a carry ripples down the chain.

A purely combinational decoder turns the 3-bit count into a 4-bit pattern that walks like a four-stage twisted-ring (Johnson) code. Ones fill in from bit 0 up to bit 3, then empty out from bit 0 up to bit 3. A single bit of the pattern flips on each counted pulse.

An active-low clear, independent of the pulse input, returns everything to zero. There is no data stream through the block, so no valid/ready handshake applies and back-pressure does not arise. All pins are plain control and status levels.

Top module: `ripple_johnson_counter`

## Requirements
- R1: `count_q` increments by one on each falling edge of `pulse_in` while `clr_n` is high, with `count_q[0]` as the least significant bit.
- R2: Stage 0 toggles on each falling edge of `pulse_in`, and stage k (k > 0) toggles only when `count_q[k-1]` goes from 1 to 0.
- R3: After count 7, the next falling edge of `pulse_in` returns `count_q` to 0.
- R4: `pattern_o` (bit 3 down to bit 0) is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 for counts 0 through 7. Bit i is 1 exactly when i < count <= i + 4.
- R5: On each counted pulse, exactly one bit of `pattern_o` changes value.
- R6: While `clr_n` is low, `count_q` is 0 and `pattern_o` is 0000, whatever `pulse_in` does. Releasing `clr_n` does not itself count.
- R7: A rising edge of `pulse_in` leaves `count_q` and `pattern_o` unchanged.
- R8: `pattern_o[3]` always equals `count_q[2]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pulse_in | input | 1 | Pulses to be counted; the falling edge counts |
| clr_n | input | 1 | Active-low clear, acts immediately |
| count_q | output | 3 | Binary count, bit 0 least significant |
| pattern_o | output | 4 | Twisted-ring decode of the count |

## Verification
Every result is due within the same falling edge of `pulse_in` that causes it, once the carry has run through three stages. A clear takes effect as soon as `clr_n` falls. The bench therefore samples 2 ns after each falling edge, and 1 ns after each rising edge or change of the clear. This keeps every sample clear of both the edge and the transient ripple states. Expected count and pattern come from a bench model that steps on each applied falling edge and resets on each clear.

// File: rtl/ripple_pkg.sv
package ripple_pkg;
  localparam int unsigned RJC_DEFAULT_STAGES = 3;

  function automatic int unsigned ring_width(input int unsigned stages);
    return (1 << stages) / 2;
  endfunction
endpackage

// File: rtl/ripple_toggle_stage.sv
module ripple_toggle_stage (
  input  logic tog_i,
  input  logic clr_n,
  output logic q_o
);
  logic d_next;
  logic prev_q;
  logic armed;

  assign d_next = ~q_o;

  always_ff @(negedge tog_i or negedge clr_n) begin
    if (!clr_n) q_o <= 1'b0;
    else        q_o <= d_next;
  end

  // Between two counted falling edges the stage must have flipped once (R2)
  always_ff @(negedge tog_i or negedge clr_n) begin
    if (!clr_n) begin
      armed  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (armed) assert_stage_toggle_R2: assert (q_o != prev_q);
      armed  <= 1'b1;
      prev_q <= q_o;
    end
  end
endmodule

// File: rtl/johnson_decoder.sv
module johnson_decoder #(
  parameter int unsigned CNT_W = 3,
  localparam int unsigned RING_W = (1 << CNT_W) / 2
) (
  input  logic [CNT_W-1:0]  count_i,
  output logic [RING_W-1:0] pattern_o
);
  logic [CNT_W:0] cval;
  assign cval = {1'b0, count_i};

  generate
    for (genvar i = 0; i < RING_W; i++) begin : g_bit
      localparam logic [CNT_W:0] LO = i;
      localparam logic [CNT_W:0] HI = i + RING_W;
      assign pattern_o[i] = (cval > LO) && (cval <= HI);
    end
  endgenerate
endmodule

// File: rtl/ripple_johnson_counter.sv
module ripple_johnson_counter
  import ripple_pkg::*;
#(
  parameter int unsigned STAGES = RJC_DEFAULT_STAGES,
  localparam int unsigned RING_W = (1 << STAGES) / 2
) (
  input  logic              pulse_in,
  input  logic              clr_n,
  output logic [STAGES-1:0] count_q,
  output logic [RING_W-1:0] pattern_o
);
  logic [STAGES-1:0] stage_clk;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stage_clk[k] = pulse_in;
      end else begin : g_next
        assign stage_clk[k] = count_q[k-1];
      end
      ripple_toggle_stage u_stage (
        .tog_i (stage_clk[k]),
        .clr_n (clr_n),
        .q_o   (count_q[k])
      );
    end
  endgenerate

  johnson_decoder #(.CNT_W(STAGES)) u_dec (
    .count_i   (count_q),
    .pattern_o (pattern_o)
  );

  // Checks taken on rising pulse edges, when the ripple has long settled
  logic [RING_W-1:0] last_pat;
  logic              pat_armed;

  always_ff @(posedge pulse_in or negedge clr_n) begin
    if (!clr_n) begin
      pat_armed <= 1'b0;
      last_pat  <= '0;
    end else begin
      if (pat_armed)
        assert_single_flip_R5: assert ($countones(pattern_o ^ last_pat) == 1);
      assert_msb_track_R8: assert (pattern_o[RING_W-1] == count_q[STAGES-1]);
      pat_armed <= 1'b1;
      last_pat  <= pattern_o;
    end
  end

  always_ff @(posedge pulse_in) begin
    if (!clr_n) assert_clear_zero_R6: assert (count_q == '0 && pattern_o == '0);
  end
endmodule

// File: tb/ripple_johnson_counter_tb.sv
module ripple_johnson_counter_tb_top;
  logic       pulse_in;
  logic       clr_n;
  logic [2:0] count_q;
  logic [3:0] pattern_o;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 0;

  ripple_johnson_counter dut_i (
    .pulse_in  (pulse_in),
    .clr_n     (clr_n),
    .count_q   (count_q),
    .pattern_o (pattern_o)
  );

  function automatic logic [3:0] ring_of(input int n);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (n > i) && (n <= i + 4);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk({req, " count"}, count_q, model);
    chk("R4 pattern", pattern_o, ring_of(model));
    chk("R8 msb", pattern_o[3], count_q[2]);
  endtask

  // One 8 ns pulse (125 MHz rate); falling edge counts
  task automatic pulse();
    logic [2:0] before_c;
    logic [3:0] before_p;
    pulse_in = 1'b1;
    #1;
    chk("R7 rise count", count_q, model);
    chk("R7 rise pattern", pattern_o, ring_of(model));
    before_c = count_q;
    before_p = pattern_o;
    #3;
    pulse_in = 1'b0;
    model = (model + 1) % 8;
    #2;
    check_state(model == 0 ? "R3" : "R1");
    chk("R5 one flip", $countones(pattern_o ^ before_p), 1);
    // R2: ripple rule per stage
    chk("R2 stage0", count_q[0] != before_c[0], 1);
    for (int k = 1; k < 3; k++)
      chk("R2 stagek", count_q[k] != before_c[k],
          (before_c[k-1] == 1'b1) && (count_q[k-1] == 1'b0));
    #2;
  endtask

  task automatic clear_seq(input logic level);
    pulse_in = level;
    #2;
    clr_n = 1'b0;
    model = 0;
    #1;
    chk("R6 clear count", count_q, 0);
    chk("R6 clear pattern", pattern_o, 0);
    pulse_in = ~level;
    #1;
    pulse_in = level;
    #1;
    pulse_in = 1'b0;
    #1;
    chk("R6 held count", count_q, 0);
    clr_n = 1'b1;
    #2;
    check_state("R6");
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd20240607);
    pulse_in = 1'b0;
    clr_n    = 1'b0;
    #3;
    chk("R6 reset count", count_q, 0);
    chk("R6 reset pattern", pattern_o, 0);
    #5;
    clr_n = 1'b1;
    #3;
    check_state("R6");
    // Directed: full cycle with wrap (R3, R4)
    for (int n = 0; n < 9; n++) pulse();
    // Directed: clear with pulse high and low
    for (int n = 0; n < 5; n++) pulse();
    clear_seq(1'b1);
    for (int n = 0; n < 3; n++) pulse();
    clear_seq(1'b0);
    // Random mix
    for (int it = 0; it < 400; it++) begin
      r = $urandom % 16;
      if (r == 0) clear_seq(1'($urandom % 2));
      else pulse();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule